// File: doc/BRIEF.md
# Fractional Rate Pulse-Deletion Divider

This block produces clock-enable strobes at a non-integer fraction of its input clock rate. It does not gate the clock. Each enabled input cycle adds a fixed step to a modular phase accumulator. When the new sum reaches the modulus, that cycle is passed: the modulus is subtracted and a one-cycle strobe is registered. Any other cycle is deleted. Over every P enabled cycles, exactly Q are passed. The spacing of the passed cycles is irregular; only the average rate is exact.

Two accumulator stages can be chained on the same clock. The second stage advances only on the first stage's strobes. With the default settings, stage one passes 22 of every 26 enabled cycles and stage two passes 390 of every 423 stage-one strobes. A terminal integer stage counts the final strobes and toggles a square output on every tenth one, giving a further divide-by-20.

There is no data path and no back-pressure. The enable input is a plain qualifier that is sampled every cycle, and every output is a plain registered level. All flops clear on an asynchronous active-low reset.

Top module: `frac_rate_divider`

## Requirements
- R1: While rst_n is low, ph1_stb_o, ph2_stb_o and sq_o are 0, and both accumulators are cleared, so the pass pattern restarts from zero after reset.
- R2: On a clock edge where en_i is 1, stage one adds Q1. If the sum is at least P1, the stage subtracts P1 and drives ph1_stb_o high for exactly the next cycle. Otherwise it keeps the sum and ph1_stb_o is 0. In other words, the n-th enabled cycle after reset is passed exactly when floor(n*Q1/P1) > floor((n-1)*Q1/P1).
- R3: An edge with en_i at 0 leaves the stage-one accumulator unchanged and gives ph1_stb_o = 0 in the next cycle.
- R4: Starting from reset, every run of P1 enabled cycles (26 by default) yields exactly Q1 (22) stage-one strobes.
- R5: Stage two advances only on edges where ph1_stb_o is 1. ph2_stb_o is high only in the cycle after a ph1_stb_o cycle.
- R6: The m-th stage-one strobe after reset produces a stage-two strobe exactly when floor(m*Q2/P2) > floor((m-1)*Q2/P2). Hence 423 stage-one strobes give exactly 390 stage-two strobes.
- R7: sq_o inverts in the cycle after every TOG_N-th (10th) stage-two strobe since reset, and holds its value at all other times.
- R8: Each accumulator always stays below its modulus. Its width is ceil(log2(P+Q)), so the add-then-compare cannot overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables stage-one accumulation for this cycle |
| ph1_stb_o | output | 1 | Stage-one pass strobe, one cycle wide |
| ph2_stb_o | output | 1 | Stage-two pass strobe, one cycle wide |
| sq_o | output | 1 | Square output of the terminal toggle stage |

## Verification
The hardest behaviour to reach is deep in the cascade. A square-output toggle needs ten stage-two strobes. A stage-two deletion happens only once per roughly a dozen stage-one strobes, and it appears only after a long, gap-ridden history of enables. The stimulus holds en_i with random density (including long idle bursts) for tens of thousands of cycles, so the cascade passes its accumulator wrap points many times. A bench model based on the floor formula predicts every strobe and toggle cycle by cycle. Directed runs from a fresh reset, with en_i held high, count complete P1 and P2 windows. A mid-run reset then confirms that the pattern restarts.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  // Width that holds any value of acc + step when acc < modulus.
  function automatic int unsigned acc_width(input int unsigned modulus, input int unsigned step);
    return $clog2(modulus + step);
  endfunction
endpackage

// File: rtl/pd_accum_stage.sv
module pd_accum_stage #(
  parameter int unsigned MOD  = 26,
  parameter int unsigned STEP = 22,
  localparam int unsigned W   = frac_div_pkg::acc_width(MOD, STEP)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic         stb_o,
  output logic [W-1:0] acc_o
);
  localparam logic [W-1:0] MOD_V  = W'(MOD);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] acc_q;
  logic [W-1:0] sum;
  logic         pass;

  assign sum  = acc_q + STEP_V;
  assign pass = (sum >= MOD_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stb_o <= 1'b0;
    end else if (adv_i) begin
      acc_q <= pass ? (sum - MOD_V) : sum;
      stb_o <= pass;
    end else begin
      stb_o <= 1'b0;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/pd_toggle_stage.sv
module pd_toggle_stage #(
  parameter int unsigned TOG_N = 10,
  localparam int unsigned CW   = (TOG_N > 1) ? $clog2(TOG_N) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic sq_o
);
  localparam logic [CW-1:0] LAST = CW'(TOG_N - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_o  <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        sq_o  <= ~sq_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frac_rate_divider.sv
module frac_rate_divider #(
  parameter int unsigned P1        = 26,
  parameter int unsigned Q1        = 22,
  parameter int unsigned P2        = 423,
  parameter int unsigned Q2        = 390,
  parameter bit          USE_STG2  = 1'b1,
  parameter int unsigned TOG_N     = 10,
  localparam int unsigned W1       = frac_div_pkg::acc_width(P1, Q1),
  localparam int unsigned W2       = frac_div_pkg::acc_width(P2, Q2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic ph1_stb_o,
  output logic ph2_stb_o,
  output logic sq_o
);
  logic [W1-1:0] acc1_w;
  logic [W2-1:0] acc2_w;

  pd_accum_stage #(.MOD(P1), .STEP(Q1)) u_stg1 (
    .clk(clk), .rst_n(rst_n), .adv_i(en_i), .stb_o(ph1_stb_o), .acc_o(acc1_w)
  );

  generate
    if (USE_STG2) begin : g_stg2
      pd_accum_stage #(.MOD(P2), .STEP(Q2)) u_stg2 (
        .clk(clk), .rst_n(rst_n), .adv_i(ph1_stb_o), .stb_o(ph2_stb_o), .acc_o(acc2_w)
      );
    end else begin : g_bypass
      assign ph2_stb_o = ph1_stb_o;
      assign acc2_w    = '0;
    end
  endgenerate

  pd_toggle_stage #(.TOG_N(TOG_N)) u_tog (
    .clk(clk), .rst_n(rst_n), .tick_i(ph2_stb_o), .sq_o(sq_o)
  );
endmodule

// File: rtl/frac_div_chk.sv
module frac_div_chk #(
  parameter int unsigned P1 = 26,
  parameter int unsigned P2 = 423,
  parameter int unsigned W1 = 6,
  parameter int unsigned W2 = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic          ph1_stb_o,
  input logic          ph2_stb_o,
  input logic          sq_o,
  input logic [W1-1:0] acc1,
  input logic [W2-1:0] acc2
);
  a_r2_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_stb_o |-> $past(en_i));

  a_r3_idle_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> ($stable(acc1) && !ph1_stb_o));

  a_r5_stage2_fed_by_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_stb_o |-> $past(ph1_stb_o));

  a_r7_square_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sq_o) |-> $past(ph2_stb_o));

  a_r8_acc1_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    acc1 < W1'(P1));

  a_r8_acc2_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    acc2 < W2'(P2));
endmodule

bind frac_rate_divider frac_div_chk #(.P1(P1), .P2(P2), .W1(W1), .W2(W2)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .ph1_stb_o(ph1_stb_o),
  .ph2_stb_o(ph2_stb_o), .sq_o(sq_o), .acc1(acc1_w), .acc2(acc2_w)
);

// File: tb/sim_frac_rate_divider.sv
module sim_frac_rate_divider;
  localparam longint P1 = 26, Q1 = 22, P2 = 423, Q2 = 390, TN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic ph1_stb_o, ph2_stb_o, sq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  longint n1, m2, k3;
  bit e1, e2, esq;
  bit last_en;

  always #5 clk = ~clk;

  frac_rate_divider u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .ph1_stb_o(ph1_stb_o), .ph2_stb_o(ph2_stb_o), .sq_o(sq_o)
  );

  function automatic bit passes(input longint n, input longint p, input longint q);
    return ((n * q) / p) != (((n - 1) * q) / p);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: compare outputs of the previous edge, then drive and predict.
  task automatic step(input bit e, input bit r);
    bit n_e1, n_e2, n_sq;
    @(negedge clk);
    if (!rst_n) begin
      check(ph1_stb_o, 1'b0, "R1 stb1 in reset");
      check(ph2_stb_o, 1'b0, "R1 stb2 in reset");
      check(sq_o, 1'b0, "R1 sq in reset");
    end else begin
      check(ph1_stb_o, e1, last_en ? "R2 stage1 pass" : "R3 idle cycle");
      check(ph2_stb_o, e2, "R5/R6 stage2 pass, R8 phase");
      check(sq_o, esq, "R7 square toggle");
    end
    rst_n = r;
    en_i  = e;
    last_en = e;
    if (!r) begin
      n1 = 0; m2 = 0; k3 = 0; e1 = 0; e2 = 0; esq = 0;
    end else begin
      n_sq = esq;
      if (e2) begin
        k3++;
        if (k3 == TN) begin k3 = 0; n_sq = ~esq; end
      end
      n_e2 = 1'b0;
      if (e1) begin m2++; n_e2 = passes(m2, P2, Q2); end
      n_e1 = 1'b0;
      if (e) begin n1++; n_e1 = passes(n1, P1, Q1); end
      e1 = n_e1; e2 = n_e2; esq = n_sq;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int s1cnt, s2cnt, seed;
    seed = 7;
    void'($urandom(seed));
    // R1: reset held with enable high
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    // R4: full windows of P1 enabled cycles
    s1cnt = 0;
    for (int i = 0; i < 4 * P1; i++) begin
      step(1'b1, 1'b1);
      if (ph1_stb_o) s1cnt++;
    end
    step(1'b0, 1'b1);
    if (ph1_stb_o) s1cnt++;
    check(s1cnt == 4 * Q1, 1'b1, "R4 window count");
    if (s1cnt != 4 * Q1) $display("FAIL R4 count actual=%0d expected=%0d", s1cnt, 4 * Q1);
    // R6: fresh reset, count stage2 strobes over P2 stage1 strobes
    step(1'b0, 1'b0);
    s1cnt = 0; s2cnt = 0;
    while (s1cnt < P2) begin
      step(1'b1, 1'b1);
      if (ph1_stb_o) s1cnt++;
      if (ph2_stb_o) s2cnt++;
    end
    step(1'b0, 1'b1);
    if (ph2_stb_o) s2cnt++;
    check(s2cnt == Q2, 1'b1, "R6 ratio count");
    if (s2cnt != Q2) $display("FAIL R6 count actual=%0d expected=%0d", s2cnt, Q2);
    // Random density enables with idle bursts
    for (int i = 0; i < 30000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 2) begin
        for (int j = 0; j < 40; j++) step(1'b0, 1'b1);
      end else begin
        step(r < 80, 1'b1);
      end
      if (i == 15000) begin
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
      end
    end
    step(1'b0, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule